// File: doc/BRIEF.md
# AC97 Link Frame Transmitter

This block drives the outgoing serial data line of an AC97 digital link. It runs on the bit clock and follows an externally generated frame sync. Each frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit slots, with every slot sent most significant bit first. Slot words come from a transmit word FIFO through a valid/ready pair. One word is taken at the moment each slot starts. Slot 0 uses the low 16 bits of its word and the other slots use the low 20 bits.

Transmission depends on the codec-ready status that a companion receiver reports once per frame, as a ready value paired with a strobe. The receiver only learns this status after a frame has already begun. For that reason a positive report arms the transmitter, and sending begins with the next frame. A negative report silences the line at once and stops the FIFO pops. If a word is missing when a slot starts, that slot goes out as zeros and an underflow pulse marks the event.

Top module: `ac97_link_tx`

## Requirements
- R1: The clock edge at which sync_i is first sampled high after being low starts a frame. After that edge, sdo_o shows frame bit 0. Frame bit n appears n edges later.
- R2: Frame bits 0..15 are slot 0. They carry bits 15 down to 0 of the word popped at the frame-start edge, MSB first. The tag flags sit at word bits 15 (frame valid), 14 (control address valid), 13 (control data valid), 12 (left playback valid) and 11 (right playback valid).
- R3: Slots 1..12 are 20 bits each and start at frame bits 16+20*(k-1). Each carries bits 19 down to 0 of its word, MSB first. After frame bit 255, sdo_o stays low until the next frame start.
- R4: From reset until a ready strobe (rdy_stb_i high with rdy_i high) has been seen, sdo_o stays low and fifo_rd_o stays low.
- R5: After a ready strobe, sending begins at the next frame start, never inside the current frame. A ready strobe sampled on the same edge as a frame start does not make that frame send.
- R6: A not-ready strobe (rdy_stb_i high with rdy_i low) forces sdo_o low from that edge onward and stops all pops. Later frames stay silent until a new ready strobe arrives.
- R7: While sending, fifo_rd_o is high for exactly one cycle at each of the 13 slot starts. That cycle is the cycle before the edge that puts the slot's MSB on sdo_o. The transmitter sends 13 pops per complete frame.
- R8: When fifo_valid_i is low at a sending slot start, that slot goes out as all zeros and underflow_o is high for that cycle.
- R9: A frame start that arrives before bit 255 abandons the current frame and restarts at slot 0 with a fresh pop.
- R10: Holding sync_i high does not start further frames. Only a low-to-high change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Frame sync; its rising edge starts a frame |
| rdy_i | input | 1 | Codec-ready value reported by the receiver |
| rdy_stb_i | input | 1 | One-cycle strobe qualifying rdy_i |
| fifo_data_i | input | 20 | Head word of the transmit FIFO |
| fifo_valid_i | input | 1 | FIFO holds at least one word |
| fifo_rd_o | output | 1 | Pop request; a word moves when this and fifo_valid_i are both high |
| sdo_o | output | 1 | Serial link data |
| underflow_o | output | 1 | Pulses when a sending slot starts with the FIFO empty |

## Verification
A wrong slot or bit count changes the position of every later bit. It shows within the same frame as a misplaced MSB or a pop at the wrong frame bit, at the latest by the next slot boundary, 20 clocks away. A wrong link state shows as pops or nonzero data during a frame that must be silent, or as a silent frame that should carry data, so it appears within one 256-clock frame. A shift register that keeps stale contents shows as nonzero bits after a stop, after an underflow slot, or after bit 255.

// File: rtl/ac97_tx_pkg.sv
// Shared types and helpers for the link transmitter.
// Assumes the tag slot is never wider than a data slot.
package ac97_tx_pkg;

    // Link gating state: silent, armed for the next frame, or sending.
    typedef enum logic [1:0] {
        LINK_IDLE  = 2'd0,
        LINK_ARMED = 2'd1,
        LINK_SEND  = 2'd2
    } link_state_e;

    // Width in bits of slot idx, given the tag and data slot widths.
    function automatic int slot_bits(input int idx, input int tag_w, input int slot_w);
        return (idx == 0) ? tag_w : slot_w;
    endfunction

endpackage

// File: rtl/ac97_slot_sched.sv
// Frame timing: detects the sync rising edge and tracks slot index and bit
// offset within the slot. Flags every edge where a new slot is loaded.
// Assumes SLOT_W >= TAG_W and N_SLOTS >= 2.
module ac97_slot_sched #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 13,
    localparam int IDX_W  = $clog2(N_SLOTS),
    localparam int BIT_W  = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic             sync_edge_o,
    output logic             load_o,
    output logic             tag_o,
    output logic             in_frame_o,
    output logic [IDX_W-1:0] slot_o,
    output logic [BIT_W-1:0] bit_o
);
    import ac97_tx_pkg::*;

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_SLOTS - 1);

    logic             sync_q;
    logic             in_frame_q;
    logic [IDX_W-1:0] slot_q;
    logic [BIT_W-1:0] bit_q;
    logic [BIT_W-1:0] last_bit_idx;
    logic             at_slot_end;
    logic             sync_edge;

    // Rising edge of sync as seen at this clock.
    assign sync_edge = sync_i & ~sync_q;

    // Last bit offset of the slot in progress.
    always_comb begin
        last_bit_idx = (slot_q == '0) ? BIT_W'(TAG_W - 1) : BIT_W'(SLOT_W - 1);
        at_slot_end  = in_frame_q && (bit_q == last_bit_idx);
    end

    // Load a new slot on frame start or on the boundary between slots.
    assign load_o      = sync_edge | (at_slot_end && (slot_q != LAST_SLOT));
    assign tag_o       = sync_edge;
    assign sync_edge_o = sync_edge;
    assign in_frame_o  = in_frame_q;
    assign slot_o      = slot_q;
    assign bit_o       = bit_q;

    // Advance the slot and bit position; every sync edge restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q     <= 1'b0;
            in_frame_q <= 1'b0;
            slot_q     <= '0;
            bit_q      <= '0;
        end else begin
            sync_q <= sync_i;
            if (sync_edge) begin
                in_frame_q <= 1'b1;
                slot_q     <= '0;
                bit_q      <= '0;
            end else if (at_slot_end) begin
                bit_q <= '0;
                if (slot_q == LAST_SLOT) begin
                    in_frame_q <= 1'b0;
                    slot_q     <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else if (in_frame_q) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    AST_BIT_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_q |-> (int'(bit_q) < slot_bits(int'(slot_q), TAG_W, SLOT_W))); // R3

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> (in_frame_q && slot_q == '0 && bit_q == '0)); // R9

    AST_HELD_SYNC_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && $past(sync_i)) |-> !tag_o); // R10

endmodule

// File: rtl/ac97_link_gate.sv
// Codec-ready gating. A ready strobe arms the link, and the next frame start
// begins sending. A not-ready strobe silences the link at once.
// Assumes at most one strobe per frame from the companion receiver.
module ac97_link_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_edge_i,
    input  logic rdy_i,
    input  logic rdy_stb_i,
    output logic live_o,
    output logic sending_o,
    output logic kill_o
);
    import ac97_tx_pkg::*;

    link_state_e state_q, state_d;

    // Next link state: a not-ready report wins over everything else.
    always_comb begin
        state_d = state_q;
        if (rdy_stb_i && !rdy_i) begin
            state_d = LINK_IDLE;
        end else begin
            case (state_q)
                LINK_IDLE:  if (rdy_stb_i) state_d = LINK_ARMED;
                LINK_ARMED: if (sync_edge_i) state_d = LINK_SEND;
                LINK_SEND:  state_d = LINK_SEND;
                default:    state_d = LINK_IDLE;
            endcase
        end
    end

    // A slot loaded on this edge carries data only if the link sends afterwards.
    assign live_o    = (state_d == LINK_SEND);
    assign sending_o = (state_q == LINK_SEND);
    assign kill_o    = (state_q == LINK_SEND) && rdy_stb_i && !rdy_i;

    // Hold the link state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINK_IDLE;
        else        state_q <= state_d;
    end

    AST_SEND_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LINK_SEND) |-> $past(sync_edge_i)); // R5

    AST_NOT_READY_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_stb_i && !rdy_i) |=> (state_q == LINK_IDLE)); // R6

endmodule

// File: rtl/ac97_slot_shifter.sv
// Slot shift register. It loads a FIFO word MSB-aligned, or zeros when the
// link is silent or the FIFO is empty, then shifts one bit per clock.
// Assumes WORD_W >= SLOT_W >= TAG_W.
module ac97_slot_shifter #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int WORD_W = 20,
    localparam int PAD_W = SLOT_W - TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              tag_i,
    input  logic              live_i,
    input  logic              kill_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdo_o
);
    logic [SLOT_W-1:0] sh_q;
    logic [SLOT_W-1:0] tag_img;
    logic [SLOT_W-1:0] data_img;

    // MSB-align the tag word; the variant depends on whether padding exists.
    generate
        if (PAD_W > 0) begin : g_tag_pad
            assign tag_img = {word_i[TAG_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_tag_full
            assign tag_img = word_i[SLOT_W-1:0];
        end
    endgenerate

    assign data_img = word_i[SLOT_W-1:0];
    assign sdo_o    = sh_q[SLOT_W-1];

    // Load on slot start, clear on stop, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            if (live_i && valid_i) sh_q <= tag_i ? tag_img : data_img;
            else                   sh_q <= '0;
        end else if (kill_i) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad_chk
            AST_TAG_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (load_i && tag_i) |=> (sh_q[PAD_W-1:0] == '0)); // R2
        end
    endgenerate

endmodule

// File: rtl/ac97_link_tx.sv
// AC97 link frame transmitter top. It ties frame timing, ready gating and the
// slot shifter together, and requests one FIFO word per slot while sending.
// Assumes the FIFO presents its head word with fifo_valid_i and
// pops on fifo_rd_o && fifo_valid_i at the clock edge.
module ac97_link_tx #(
    parameter int TAG_W   = 16,
    parameter int SLOT_W  = 20,
    parameter int N_SLOTS = 13,
    parameter int WORD_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              rdy_i,
    input  logic              rdy_stb_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    input  logic              fifo_valid_i,
    output logic              fifo_rd_o,
    output logic              sdo_o,
    output logic              underflow_o
);
    localparam int IDX_W = $clog2(N_SLOTS);
    localparam int BIT_W = $clog2(SLOT_W);

    logic             sync_edge;
    logic             load;
    logic             tag;
    logic             in_frame;
    logic [IDX_W-1:0] slot;
    logic [BIT_W-1:0] bit_pos;
    logic             live;
    logic             sending;
    logic             kill;

    ac97_slot_sched #(
        .TAG_W   (TAG_W),
        .SLOT_W  (SLOT_W),
        .N_SLOTS (N_SLOTS)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .sync_edge_o (sync_edge),
        .load_o      (load),
        .tag_o       (tag),
        .in_frame_o  (in_frame),
        .slot_o      (slot),
        .bit_o       (bit_pos)
    );

    ac97_link_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_edge_i (sync_edge),
        .rdy_i       (rdy_i),
        .rdy_stb_i   (rdy_stb_i),
        .live_o      (live),
        .sending_o   (sending),
        .kill_o      (kill)
    );

    ac97_slot_shifter #(
        .TAG_W  (TAG_W),
        .SLOT_W (SLOT_W),
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .tag_i   (tag),
        .live_i  (live),
        .kill_i  (kill),
        .valid_i (fifo_valid_i),
        .word_i  (fifo_data_i),
        .sdo_o   (sdo_o)
    );

    // Request a word at each slot start of a sending frame; flag a missing word.
    assign fifo_rd_o   = load && live;
    assign underflow_o = load && live && !fifo_valid_i;

    AST_QUIET_WHEN_NOT_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !sending |-> !sdo_o); // R4

    AST_UNDERFLOW_ZERO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> !sdo_o); // R8

    AST_POP_AT_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd_o && !sync_edge) |-> (in_frame && bit_pos != '0)); // R7

endmodule

// File: tb/tb_ac97_link_tx.sv
`timescale 1ns/1ps
module tb_ac97_link_tx;
    localparam int FRAME = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic        rdy_i = 1'b0;
    logic        rdy_stb_i = 1'b0;
    logic [19:0] fifo_data_i;
    logic        fifo_valid_i;
    logic        fifo_rd_o;
    logic        sdo_o;
    logic        underflow_o;

    int compared = 0;
    int mismatched = 0;

    logic [19:0] mem [0:511];
    int head = 0;
    int tail = 0;
    logic got [0:FRAME-1];
    int pops, ufs, base, avail;

    always #4 clk = ~clk;

    assign fifo_valid_i = (head < tail);
    assign fifo_data_i  = fifo_valid_i ? mem[head] : 20'h0;

    ac97_link_tx dut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .rdy_i(rdy_i),
        .rdy_stb_i(rdy_stb_i), .fifo_data_i(fifo_data_i),
        .fifo_valid_i(fifo_valid_i), .fifo_rd_o(fifo_rd_o),
        .sdo_o(sdo_o), .underflow_o(underflow_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int n);
        for (int k = 0; k < n; k++) begin
            mem[tail] = 20'((tail * 32'h0001_3579) ^ 32'h000A_5C3F);
            tail++;
        end
    endtask

    // One clock: drive at negedge, see pop, step, sample after the edge.
    task automatic step(input logic s, input logic stb, input logic rv, output logic bitv);
        logic took, uf;
        sync_i = s; rdy_stb_i = stb; rdy_i = rv;
        #1;
        took = fifo_rd_o && fifo_valid_i;
        uf = underflow_o;
        @(posedge clk);
        @(negedge clk);
        if (took) begin head++; pops++; end
        if (uf) ufs++;
        bitv = sdo_o;
    endtask

    task automatic run_frame(input int len, input bit hold, input int stb_at, input logic stb_val);
        logic b;
        pops = 0; ufs = 0; base = head; avail = tail - head;
        for (int i = 0; i < len; i++) begin
            step((i == 0) || hold, i == stb_at, stb_val, b);
            got[i] = b;
        end
    endtask

    task automatic run_idle(input int n, input logic s, output int ones);
        logic b;
        ones = 0; pops = 0; ufs = 0;
        for (int i = 0; i < n; i++) begin
            step(s, 1'b0, 1'b0, b);
            if (b) ones++;
        end
    endtask

    function automatic int slot_start(input int s);
        return (s == 0) ? 0 : 16 + 20 * (s - 1);
    endfunction

    function automatic logic exp_bit(input int p);
        int s, off, w;
        logic [19:0] wd;
        if (p < 16) begin s = 0; off = p; w = 16; end
        else begin s = 1 + (p - 16) / 20; off = (p - 16) % 20; w = 20; end
        wd = (s < avail) ? mem[base + s] : 20'h0;
        return wd[w - 1 - off];
    endfunction

    // Compare a captured frame and its pop/underflow counts.
    task automatic chk_frame(input string req, input int len, input bit active, input int stop_at);
        int bad, first, lim, loads, ep, eu;
        bad = 0; first = -1;
        for (int i = 0; i < len; i++) begin
            logic e;
            e = (active && i < stop_at) ? exp_bit(i) : 1'b0;
            if (got[i] !== e) begin bad++; if (first < 0) first = i; end
        end
        if (bad != 0) $display("  first bad bit index %0d", first);
        chk(req, "bits mismatched", bad, 0);
        lim = (len < stop_at) ? len : stop_at;
        loads = 0;
        for (int s = 0; s < 13; s++) if (slot_start(s) < lim) loads++;
        ep = active ? ((loads < avail) ? loads : avail) : 0;
        eu = active ? loads - ep : 0;
        chk(req, "pop count", pops, ep);
        chk(req, "underflow count", ufs, eu);
    endtask

    task automatic t_reset;
        chk("R4", "sdo after reset", int'(sdo_o), 0);
        chk("R4", "pop after reset", int'(fifo_rd_o), 0);
        chk("R4", "underflow after reset", int'(underflow_o), 0);
    endtask

    task automatic t_not_ready;
        push(13);
        run_frame(FRAME, 1'b0, -1, 1'b0);
        chk_frame("R4", FRAME, 1'b0, FRAME);
    endtask

    task automatic t_start;
        int ones;
        run_frame(FRAME, 1'b0, 40, 1'b1);
        chk_frame("R5", FRAME, 1'b0, FRAME);
        run_frame(FRAME, 1'b0, -1, 1'b0);
        chk_frame("R1_R2_R3_R7", FRAME, 1'b1, FRAME);
        run_idle(20, 1'b0, ones);
        chk("R3", "ones after bit 255", ones, 0);
        chk("R3", "pops after bit 255", pops, 0);
    endtask

    task automatic t_underflow;
        push(5);
        run_frame(FRAME, 1'b0, -1, 1'b0);
        chk_frame("R8", FRAME, 1'b1, FRAME);
    endtask

    task automatic t_resync;
        push(20);
        run_frame(120, 1'b0, -1, 1'b0);
        chk_frame("R9", 120, 1'b1, FRAME);
        run_frame(FRAME, 1'b0, -1, 1'b0);
        chk_frame("R9", FRAME, 1'b1, FRAME);
    endtask

    task automatic t_stop;
        push(13);
        run_frame(FRAME, 1'b0, 100, 1'b0);
        chk_frame("R6", FRAME, 1'b1, 100);
        run_frame(FRAME, 1'b0, -1, 1'b0);
        chk_frame("R6", FRAME, 1'b0, FRAME);
    endtask

    task automatic t_coincident;
        push(6);
        run_frame(FRAME, 1'b0, 0, 1'b1);
        chk_frame("R5", FRAME, 1'b0, FRAME);
        run_frame(FRAME, 1'b0, -1, 1'b0);
        chk_frame("R5", FRAME, 1'b1, FRAME);
    endtask

    task automatic t_held_sync;
        int ones;
        push(13);
        run_frame(FRAME, 1'b1, -1, 1'b0);
        chk_frame("R10", FRAME, 1'b1, FRAME);
        run_idle(40, 1'b1, ones);
        chk("R10", "ones with sync held", ones, 0);
        chk("R10", "pops with sync held", pops, 0);
        run_idle(1, 1'b0, ones);
    endtask

    initial begin
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_not_ready();
        t_start();
        t_underflow();
        t_resync();
        t_stop();
        t_coincident();
        t_held_sync();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule